// File: doc/BRIEF.md
# Credit-Guarded Fixed-Latency Read Shell

This block sits in front of a synchronous read-only memory whose read data appears a fixed number of cycles after the address, with no way to stall or hold it. It turns that memory into a decoupled unit. Requests carry an address and use a valid/ready handshake. Responses carry data and use a valid/ready handshake too, so the consumer may stall.

Because returning data cannot be refused, the shell reserves a response-buffer slot when it accepts each request. A credit counter starts at the buffer depth. Each accepted request takes one credit, and each response the consumer takes hands one back. A one-bit tag travels down a delay line as long as the memory latency, so only real reads write into the buffer. Responses leave in request order.

When the buffer depth is at least the read latency plus one, and the consumer never stalls, requests are accepted on every cycle.

Top module: `credit_ram_shell`

## Requirements
- R1: After reset, `req_ready_o` is 1 and `rsp_valid_o` is 0.
- R2: A request is accepted in a cycle where `req_valid_i` and `req_ready_o` are both 1. In that cycle `ram_re_o` is 1 and `ram_addr_o` equals `req_addr_i`. In any other cycle `ram_re_o` is 0.
- R3: The memory word for an accepted request arrives RD_LAT clock edges after acceptance and is always captured into the buffer. `rsp_valid_o` rises in the cycle after capture, and no captured word is ever lost.
- R4: Once FIFO_DEPTH requests are outstanding, `req_ready_o` is 0, unless a response is dequeued in that same cycle. A request counts as outstanding from acceptance until its response is dequeued.
- R5: A response dequeue (`rsp_valid_o` and `rsp_ready_i` both 1) returns one credit. If a request is accepted in the same cycle as a dequeue, the credit count stays unchanged, and `req_ready_o` is 1 in that cycle.
- R6: Responses come out in request order, and `rsp_data_o` holds steady while `rsp_valid_o` is 1 and `rsp_ready_i` is 0.
- R7: With FIFO_DEPTH >= RD_LAT+1 and `rsp_ready_i` held at 1, a request can be accepted on every cycle without a stall.
- R8: Every accepted request yields exactly one response, and no response appears without a request.
- R9: While `req_valid_i` is 0, changes on `req_addr_i` cause no memory read and no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_addr_i | input | ADDR_W | Read address |
| req_ready_o | output | 1 | Request can be accepted |
| rsp_valid_o | output | 1 | Response data present |
| rsp_ready_i | input | 1 | Consumer takes the response |
| rsp_data_o | output | DATA_W | Response data |
| ram_re_o | output | 1 | Memory read strobe |
| ram_addr_o | output | ADDR_W | Memory read address |
| ram_rdata_i | input | DATA_W | Memory read data, RD_LAT edges after the strobe |

## Verification
Each internal fault shows at the ports in a characteristic way.

- A credit counter that drifts shows as `req_ready_o` disagreeing with the outstanding-request count at the first cycle that crosses the limit. That happens within FIFO_DEPTH accepted requests.
- A tag delay line that is too short or too long pushes the wrong word, or pushes at the wrong time. This shows as a response-data mismatch or an early or late `rsp_valid_o` on the very first read.
- A pointer slip in the buffer shows as out-of-order data within one buffer wrap.

The bench tracks arrival cycles and outstanding counts every cycle. This catches each of these faults in the cycle it first appears.

// File: rtl/credit_ram_pkg.sv
package credit_ram_pkg;
  localparam int unsigned DEF_ADDR_W = 8;
  localparam int unsigned DEF_DATA_W = 16;
  localparam int unsigned DEF_RD_LAT = 3;
  localparam int unsigned DEF_DEPTH  = 4;

  function automatic int unsigned cnt_bits(input int unsigned n);
    return $clog2(n + 1);
  endfunction

  function automatic int unsigned ptr_bits(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/lat_tag_pipe.sv
module lat_tag_pipe #(
  parameter int unsigned LAT = 3
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           tag_i,
  output logic           tag_o,
  output logic [LAT-1:0] stages_o
);
  logic [LAT-1:0] stg_q;

  for (genvar g = 0; g < LAT; g++) begin : g_stage
    if (g == 0) begin : g_head
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[g] <= 1'b0;
        else         stg_q[g] <= tag_i;
      end
    end else begin : g_body
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[g] <= 1'b0;
        else         stg_q[g] <= stg_q[g-1];
      end
    end
  end

  assign tag_o    = stg_q[LAT-1];
  assign stages_o = stg_q;
endmodule

// File: rtl/rsp_fifo.sv
module rsp_fifo
  import credit_ram_pkg::*;
#(
  parameter int unsigned DEPTH  = 4,
  parameter int unsigned DATA_W = 16,
  localparam int unsigned PW = ptr_bits(DEPTH),
  localparam int unsigned CW = cnt_bits(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              valid_o,
  output logic [CW-1:0]     count_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [PW-1:0]     wr_q, rd_q;
  logic [CW-1:0]     cnt_q;
  logic              do_pop;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign do_pop = pop_i && (cnt_q != '0);

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i) begin
      if (push_i && (wr_q == PW'(g))) mem_q[g] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= bump(wr_q);
      if (do_pop) rd_q <= bump(rd_q);
      if (push_i && !do_pop)      cnt_q <= cnt_q + 1'b1;
      else if (!push_i && do_pop) cnt_q <= cnt_q - 1'b1;
    end
  end

  assign rdata_o = mem_q[rd_q];
  assign valid_o = (cnt_q != '0);
  assign count_o = cnt_q;
endmodule

// File: rtl/credit_ctr.sv
module credit_ctr
  import credit_ram_pkg::*;
#(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned CW = cnt_bits(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          take_i,
  input  logic          give_i,
  output logic          avail_o,
  output logic [CW-1:0] count_o
);
  logic [CW-1:0] cred_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cred_q <= CW'(DEPTH);
    else if (take_i && !give_i) cred_q <= cred_q - 1'b1;
    else if (give_i && !take_i) cred_q <= cred_q + 1'b1;
  end

  assign avail_o = (cred_q != '0);
  assign count_o = cred_q;
endmodule

// File: rtl/credit_ram_shell.sv
module credit_ram_shell
  import credit_ram_pkg::*;
#(
  parameter int unsigned ADDR_W     = DEF_ADDR_W,
  parameter int unsigned DATA_W     = DEF_DATA_W,
  parameter int unsigned RD_LAT     = DEF_RD_LAT,
  parameter int unsigned FIFO_DEPTH = DEF_DEPTH
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              req_ready_o,
  output logic              rsp_valid_o,
  input  logic              rsp_ready_i,
  output logic [DATA_W-1:0] rsp_data_o,
  output logic              ram_re_o,
  output logic [ADDR_W-1:0] ram_addr_o,
  input  logic [DATA_W-1:0] ram_rdata_i
);
  localparam int unsigned CRED_W = cnt_bits(FIFO_DEPTH);

  logic              req_fire, rsp_pop, cred_avail, land;
  logic [CRED_W-1:0] credit_cnt, fifo_cnt;
  logic [RD_LAT-1:0] pend_stages;

  assign rsp_pop     = rsp_valid_o && rsp_ready_i;
  // a same-cycle dequeue frees the slot this request reserves
  assign req_ready_o = cred_avail || rsp_pop;
  assign req_fire    = req_valid_i && req_ready_o;
  assign ram_re_o    = req_fire;
  assign ram_addr_o  = req_addr_i;

  credit_ctr #(.DEPTH(FIFO_DEPTH)) credit_i (
    .clk_i, .rst_ni,
    .take_i (req_fire),
    .give_i (rsp_pop),
    .avail_o(cred_avail),
    .count_o(credit_cnt)
  );

  lat_tag_pipe #(.LAT(RD_LAT)) tag_i (
    .clk_i, .rst_ni,
    .tag_i   (req_fire),
    .tag_o   (land),
    .stages_o(pend_stages)
  );

  rsp_fifo #(.DEPTH(FIFO_DEPTH), .DATA_W(DATA_W)) fifo_i (
    .clk_i, .rst_ni,
    .push_i (land),
    .wdata_i(ram_rdata_i),
    .pop_i  (rsp_pop),
    .rdata_o(rsp_data_o),
    .valid_o(rsp_valid_o),
    .count_o(fifo_cnt)
  );
endmodule

// File: rtl/credit_ram_shell_chk.sv
module credit_ram_shell_chk #(
  parameter int unsigned DEPTH  = 4,
  parameter int unsigned LAT    = 3,
  parameter int unsigned CW     = 3,
  parameter int unsigned DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic              rsp_valid_o,
  input logic              rsp_ready_i,
  input logic [DATA_W-1:0] rsp_data_o,
  input logic              ram_re_o,
  input logic [CW-1:0]     credit_i,
  input logic [CW-1:0]     fcnt_i,
  input logic [LAT-1:0]    pend_i
);
  // R4: credits, in-flight reads and buffered words always sum to the depth
  p_credit_balance_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(credit_i) + int'(fcnt_i) + $countones(pend_i)) == int'(DEPTH));

  p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(fcnt_i) <= int'(DEPTH));

  p_read_gated_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_re_o |-> (req_valid_i && req_ready_o));

  p_swap_neutral_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ram_re_o && rsp_valid_o && rsp_ready_i) |=> (credit_i == $past(credit_i)));

  p_rsp_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_ready_i) |=> (rsp_valid_o && $stable(rsp_data_o)));
endmodule

bind credit_ram_shell credit_ram_shell_chk #(
  .DEPTH(FIFO_DEPTH), .LAT(RD_LAT), .CW(CRED_W), .DATA_W(DATA_W)
) chk_i (
  .clk_i, .rst_ni, .req_valid_i, .req_ready_o, .rsp_valid_o, .rsp_ready_i,
  .rsp_data_o, .ram_re_o,
  .credit_i(credit_cnt), .fcnt_i(fifo_cnt), .pend_i(pend_stages)
);

// File: tb/credit_ram_shell_tb_top.sv
`timescale 1ns/1ps
module credit_ram_shell_tb_top;
  localparam int unsigned AW = 8, DW = 16, LAT = 3, DEPTH = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, rsp_ready = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic req_ready, rsp_valid, ram_re;
  logic [DW-1:0] rsp_data, ram_rdata;
  logic [AW-1:0] ram_addr;

  always #2.5 clk = ~clk;

  credit_ram_shell #(.ADDR_W(AW), .DATA_W(DW), .RD_LAT(LAT), .FIFO_DEPTH(DEPTH)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_addr_i(req_addr), .req_ready_o(req_ready),
    .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready), .rsp_data_o(rsp_data),
    .ram_re_o(ram_re), .ram_addr_o(ram_addr), .ram_rdata_i(ram_rdata)
  );

  function automatic logic [DW-1:0] word_of(input logic [AW-1:0] a);
    return DW'((32'(a) * 32'd40503) ^ 32'h5a5a);
  endfunction

  // memory model: fixed-latency delay line, garbage when idle
  logic [DW-1:0] dl_q [LAT];
  always_ff @(posedge clk) begin
    dl_q[0] <= ram_re ? word_of(ram_addr) : 16'hdead;
    for (int i = 1; i < LAT; i++) dl_q[i] <= dl_q[i-1];
  end
  assign ram_rdata = dl_q[LAT-1];

  int n_chk = 0, n_fail = 0, cyc = 0, fired = 0, popped = 0;
  int arr_t[$];
  logic [DW-1:0] arr_d[$];
  logic [DW-1:0] fifo_m[$];
  bit done = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s cycle %0d: actual %0h expected %0h", req, cyc, act, exp);
    end
  endtask

  task automatic step(input bit v, input logic [AW-1:0] a, input bit r);
    bit exp_rv, pop, exp_rdy, fire;
    @(negedge clk);
    req_valid = v; req_addr = a; rsp_ready = r;
    #1;
    while (arr_t.size() > 0 && arr_t[0] + LAT + 1 <= cyc) begin
      void'(arr_t.pop_front());
      fifo_m.push_back(arr_d.pop_front());
    end
    exp_rv = fifo_m.size() > 0;
    check(rsp_valid == exp_rv, "R3 rsp_valid timing", int'(rsp_valid), int'(exp_rv));
    pop = r && exp_rv;
    exp_rdy = ((fired - popped) < DEPTH) || pop;
    check(req_ready == exp_rdy, "R4/R5 req_ready credit", int'(req_ready), int'(exp_rdy));
    fire = v && exp_rdy;
    check(ram_re == fire, v ? "R2 read strobe" : "R9 idle address ignored", int'(ram_re), int'(fire));
    if (fire) check(ram_addr == a, "R2 read address", int'(ram_addr), int'(a));
    if (pop) begin
      check(rsp_data == fifo_m[0], "R6 in-order data", int'(rsp_data), int'(fifo_m[0]));
      void'(fifo_m.pop_front());
      popped++;
    end
    if (fire) begin
      arr_t.push_back(cyc);
      arr_d.push_back(word_of(a));
      fired++;
    end
    cyc++;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int stalls;
    void'($urandom(32'd4242));
    #12 rst_n = 1'b1;
    @(negedge clk); #1;
    check(req_ready == 1'b1, "R1 reset ready", int'(req_ready), 1);
    check(rsp_valid == 1'b0, "R1 reset rsp_valid", int'(rsp_valid), 0);

    // R9: wiggle address without valid
    for (int i = 0; i < 6; i++) step(1'b0, AW'(i * 37), 1'b1);

    // R4: fill with consumer stalled, ready must drop after DEPTH
    for (int i = 0; i < DEPTH + 4; i++) step(1'b1, AW'(8'h10 + i), 1'b0);
    check(fired == DEPTH, "R4 accepted until full", fired, DEPTH);

    // R5: request and dequeue together while out of credit
    step(1'b1, 8'hc3, 1'b1);
    check(fired == DEPTH + 1, "R5 swap accepted", fired, DEPTH + 1);
    for (int i = 0; i < 10; i++) step(1'b0, 8'h00, 1'b1);

    // R7: streaming at full rate
    stalls = 0;
    for (int i = 0; i < 40; i++) begin
      step(1'b1, AW'(i * 11 + 3), 1'b1);
      if (!req_ready) stalls++;
    end
    check(stalls == 0, "R7 full-rate stream", stalls, 0);
    for (int i = 0; i < 10; i++) step(1'b0, 8'h00, 1'b1);

    // random mix
    for (int i = 0; i < 3000; i++)
      step(($urandom % 4) != 0, AW'($urandom), ($urandom % 3) != 0);

    // drain, R8
    for (int i = 0; i < 12; i++) step(1'b0, AW'($urandom), 1'b1);
    check(fired == popped, "R8 one response per request", popped, fired);
    check(rsp_valid == 1'b0, "R8 no spurious response", int'(rsp_valid), 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule